// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This controller connects a synchronous request port to an external asynchronous static RAM. The RAM has 17 address bits, an 8-bit data bus, and three active-low strobes: chip select, output enable and write enable. A client hands over one read or one write at a time with a valid/ready handshake. The controller then drives the address, the strobes and the enable of its own data driver. When a read finishes, it returns the captured byte together with a one-cycle valid pulse.

Every access is timed by whole clock counts. Each count is the RAM's timing figure in picoseconds divided by the clock period and rounded up.

- A read holds chip select and output enable low for the address access count.
- A write pulls chip select and write enable low together and keeps output enable high, so the RAM never drives the bus during a write.
- The controller drives data only from the second strobe cycle onward and releases the bus on the same edge that ends the strobe.
- One idle cycle follows every write before any new access can start.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, until a request arrives, `req_ready_o` is 1. Chip select, output enable and write enable are high (1), `sram_dq_oe_o` is 0 and `rsp_valid_o` is 0.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 from that edge until the access, including any turnaround cycle, has completed.
- R3: A read (`req_we_i`=0) holds chip select and output enable low and write enable high for RD_CYC = ceil(T_AA_PS/CLK_PS) cycles, which is 3 with the defaults. The data bus is sampled on the edge that ends the last of these cycles. `rsp_valid_o` is then 1 for exactly the following cycle, with the sampled byte on `rsp_rdata_o`.
- R4: A write (`req_we_i`=1) holds write enable low for 1 + max(ceil(T_DW_PS/CLK_PS), ceil(T_WP_PS/CLK_PS)-1) cycles, which is 3 with the defaults. Output enable stays high throughout, and the addressed RAM byte afterwards holds the request data.
- R5: `sram_dq_oe_o` is 1 only while write enable is low and output enable is high. It is never 1 in the first strobe cycle. It falls on the same edge as write enable rises. With the defaults the data is driven for 2 cycles.
- R6: After every write, one cycle follows with chip select high and `req_ready_o` 0.
- R7: While chip select is low, `sram_addr_o` and `sram_dq_o` keep the values latched when the request was taken.
- R8: The controller never drives the bus while the RAM outputs are enabled. Output enable never falls in the cycle right after the data driver was active.
- R9: Chip select falls on the same edge as write enable and stays low for as long as write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle read completion pulse |
| rsp_rdata_o | output | 8 | Read data |
| sram_addr_o | output | 17 | RAM address |
| sram_cs_no | output | 1 | RAM chip select, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_dq_o | output | 8 | Data toward the RAM |
| sram_dq_oe_o | output | 1 | Enable of the controller's data driver |
| sram_dq_i | input | 8 | Data from the RAM bus |

## Verification
The main function is tried with several access orders: back-to-back writes to different addresses, a read after a write, a read after a read, an overwrite followed by a read-back, and a read of a location never written. Each order separates a different failure:
- Read-back after an overwrite exposes a write that lands at the wrong time or on the wrong address.
- The unwritten location exposes stale or leaked data.
- The read-after-write order exercises the turnaround cycle.

The RAM model returns a marker byte until the access count has elapsed, so a read sampled too early returns the marker instead of the stored byte. Strobe widths, driver cycles and bus ownership are tracked on every cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_STB,
    ST_WR_DRV,
    ST_TURN
  } state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 3,
  parameter int DRV_CYC = 2,
  parameter int CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             cap_o,
  output logic             cs_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_LD = CNT_W'(DRV_CYC - 1);
  localparam int               WE_CYC = 1 + DRV_CYC;

  state_e state_q, state_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cap_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        cnt_load_o = 1'b1;
        if (req_we_i) begin
          state_d = ST_WR_STB;
        end else begin
          state_d   = ST_RD;
          cnt_val_o = RD_LD;
        end
      end
      ST_RD: if (cnt_zero_i) begin
        cap_o   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_WR_STB: begin
        // strobe cycle first; driver waits one cycle
        state_d    = ST_WR_DRV;
        cnt_load_o = 1'b1;
        cnt_val_o  = DRV_LD;
      end
      ST_WR_DRV: if (cnt_zero_i) state_d = ST_TURN;
      ST_TURN:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_o  <= !(state_d inside {ST_RD, ST_WR_STB, ST_WR_DRV});
      oe_n_o  <= (state_d != ST_RD);
      we_n_o  <= !(state_d inside {ST_WR_STB, ST_WR_DRV});
      dq_oe_o <= (state_d == ST_WR_DRV);
    end
  end

  // checker support: width of current write strobe
  logic [CNT_W:0] we_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      we_low_q <= '0;
    else if (we_n_o)  we_low_q <= '0;
    else              we_low_q <= we_low_q + 1'b1;
  end

  // R5
  drv_needs_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!we_n_o && oe_n_o && !cs_n_o));
  // R5
  drv_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(!we_n_o));
  // R5
  drv_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> !dq_oe_o);
  // R4
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (we_low_q == (CNT_W+1)'(WE_CYC)));
  // R9
  cs_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !cs_n_o);
  // R9
  cs_we_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> $fell(cs_n_o));
  // R8
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_o) |-> !$past(dq_oe_o));
  // R2
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o);
  // R3
  rd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> (!cs_n_o && we_n_o));

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

  // R3
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_PS  = 8000,
  parameter int T_AA_PS = 20000,
  parameter int T_WP_PS = 15000,
  parameter int T_DW_PS = 9000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_cs_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int RD_CYC  = max2(1, ceil_div(T_AA_PS, CLK_PS));
  localparam int WP_CYC  = ceil_div(T_WP_PS, CLK_PS);
  localparam int DS_CYC  = ceil_div(T_DW_PS, CLK_PS);
  localparam int DRV_CYC = max2(1, max2(DS_CYC, WP_CYC - 1));
  localparam int CNT_W   = $clog2(max2(RD_CYC, DRV_CYC) + 1);

  logic             cnt_load, cnt_zero, accept, cap;
  logic [CNT_W-1:0] cnt_val;

  sram_ctrl_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .DRV_CYC(DRV_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .cnt_zero_i (cnt_zero),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .cap_o      (cap),
    .cs_n_o     (sram_cs_no),
    .oe_n_o     (sram_oe_no),
    .we_n_o     (sram_we_no),
    .dq_oe_o    (sram_dq_oe_o)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .cap_i   (cap),
    .dq_i    (sram_dq_i),
    .addr_o  (sram_addr_o),
    .wdata_o (sram_dq_o),
    .rdata_o (rsp_rdata_o),
    .rvalid_o(rsp_valid_o)
  );

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_addr_o));
  // R7
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_dq_o));
  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_cs_no && sram_oe_no && sram_we_no && !sram_dq_oe_o));

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int TCLK   = 8000;
  localparam int TB_RD  = (20000 + TCLK - 1) / TCLK;                 // 3
  localparam int TB_DRV = 2;                                          // max(ceil(9/8), ceil(15/8)-1)
  localparam int TB_WE  = 1 + TB_DRV;                                 // 3
  localparam logic [7:0] MARK = 8'hEE;

  // {we, addr, wdata, expected read}
  localparam int NV = 10;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 17'h00012, 8'h3C, 8'h00},
    {1'b1, 17'h1FF34, 8'hC3, 8'h00},
    {1'b0, 17'h00012, 8'h00, 8'h3C},
    {1'b0, 17'h1FF34, 8'h00, 8'hC3},
    {1'b1, 17'h00012, 8'h5A, 8'h00},
    {1'b0, 17'h00012, 8'h00, 8'h5A},
    {1'b1, 17'h10000, 8'hFF, 8'h00},
    {1'b0, 17'h10000, 8'h00, 8'hFF},
    {1'b0, 17'h1FF34, 8'h00, 8'hC3},
    {1'b0, 17'h00077, 8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, cs_n, oe_n, we_n, dq_oe;
  logic [7:0] rsp_rdata, dq_o, dq_i;
  logic [16:0] sram_addr;

  int n_chk = 0, n_bad = 0, cycles = 0;

  always #4ns clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(sram_addr), .sram_cs_no(cs_n), .sram_oe_no(oe_n), .sram_we_no(we_n),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // cycle-based RAM model, 256 bytes keyed by low address byte
  logic [7:0] mem [256];
  int rd_age;
  wire ram_drv = !cs_n && !oe_n && we_n;
  assign dq_i = (ram_drv && rd_age >= TB_RD - 1) ? mem[sram_addr[7:0]] : MARK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_age <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else begin
      rd_age <= ram_drv ? rd_age + 1 : 0;
      if (!cs_n && !we_n && dq_oe) mem[sram_addr[7:0]] <= dq_o;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor
  int we_cnt = 0, drv_cnt = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (dq_oe && ram_drv) check(0, "R8 contention", 1, 0);
      if (dq_oe && (we_n || !oe_n)) check(0, "R5 driver outside strobe", 1, 0);
      if (dq_oe && !we_n && we_cnt == 0) check(0, "R5 driver in first strobe cycle", 1, 0);
      if (!we_n && cs_n) check(0, "R9 cs high during strobe", 1, 0);
      if (!we_n) begin
        we_cnt++;
        if (dq_oe) drv_cnt++;
      end else if (we_cnt != 0) begin
        check(we_cnt == TB_WE, "R4 we width", we_cnt, TB_WE);
        check(drv_cnt == TB_DRV, "R5 driver cycles", drv_cnt, TB_DRV);
        we_cnt = 0;
        drv_cnt = 0;
      end
    end
    if (cycles > 100000) begin
      check(0, "watchdog", cycles, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_req(input logic [33:0] v);
    logic we;
    logic [16:0] a;
    logic [7:0] wd, ex;
    {we, a, wd, ex} = v;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);  // accepted on the edge in between
    req_valid = 1'b0; req_addr = '0; req_wdata = '0;
    check(!req_ready, "R2 ready low after accept", req_ready, 0);
    check(sram_addr == a, "R7 address latched", sram_addr, a);
    if (we) begin
      check(!we_n && !cs_n && oe_n && !dq_oe, "R9 strobe cycle pins", {cs_n, oe_n, we_n, dq_oe}, 4'b0100);
      @(negedge clk);
      check(dq_oe && dq_o == wd, "R7 write data driven", dq_o, wd);
      @(negedge clk);
      @(negedge clk);
      check(cs_n && !req_ready && !dq_oe, "R6 turnaround cycle", {cs_n, req_ready, dq_oe}, 3'b100);
      @(negedge clk);
      check(req_ready, "R2 ready after write", req_ready, 1);
      check(mem[a[7:0]] == wd, "R4 RAM updated", mem[a[7:0]], wd);
    end else begin
      for (int i = 1; i < TB_RD; i++) begin
        check(!cs_n && !oe_n && we_n && !rsp_valid, "R3 read strobes", {cs_n, oe_n, we_n, rsp_valid}, 4'b0010);
        @(negedge clk);
      end
      check(!oe_n && !rsp_valid, "R3 last read cycle", {oe_n, rsp_valid}, 0);
      @(negedge clk);
      check(rsp_valid && rsp_rdata == ex, "R3 read data", rsp_rdata, ex);
      check(req_ready && oe_n, "R2 ready after read", req_ready, 1);
      @(negedge clk);
      check(!rsp_valid, "R3 valid one cycle", rsp_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(req_ready && cs_n && oe_n && we_n && !dq_oe && !rsp_valid, "R1 in reset",
          {req_ready, cs_n, oe_n, we_n, dq_oe, rsp_valid}, 6'b111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && cs_n && oe_n && we_n && !dq_oe && !rsp_valid, "R1 after reset",
          {req_ready, cs_n, oe_n, we_n, dq_oe, rsp_valid}, 6'b111100);

    for (int k = 0; k < NV; k++) do_req(VEC[k]);

    // R8: read right after write: oe must not fall in the cycle after driving
    do_req({1'b1, 17'h00044, 8'hA7, 8'h00});
    do_req({1'b0, 17'h00044, 8'h00, 8'hA7});

    // R2: held-off request while busy stays pending until ready
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h00055; req_wdata = 8'h6B;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(!req_ready && !we_n, "R2 busy during write", req_ready, 0);
    repeat (3) @(negedge clk);
    check(mem[8'h55] == 8'h6B, "R4 held-off write done", mem[8'h55], 8'h6B);

    // R1: reset mid-read returns pins to idle
    req_valid = 1'b1; req_we = 1'b0; req_addr = 17'h00012;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(req_ready && cs_n && oe_n && !rsp_valid, "R1 reset aborts access",
          {req_ready, cs_n, oe_n, rsp_valid}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule